// File: doc/BRIEF.md
# Microcontroller Reset Release Sequencer

This block brings a small microcontroller core out of reset in a fixed order. An active-low external reset pin drives a short synchronizer, and the synchronizer's output is the core's internal reset. Once the internal reset releases, the core clock stays gated for a fixed number of cycles while the option configuration is read. If the clock source is a crystal or ceramic resonator, a second wait follows so the oscillator can settle. Its length is a power of two picked by a small code. With an internal oscillator or an external clock input, this second wait is skipped.

All general ports stay high-impedance until normal operation begins. A dedicated port pin drives low whenever reset is in effect. Once the core runs, software may set that pin high, so it can later act as a reset indication to outside parts. A single-cycle ready pulse marks the first cycle of normal operation.

Top module: `mcu_rst_release`

## Requirements
- R1: While rst_ni is low, core_rst_o is 1, cpu_clk_en_o is 0, port_hiz_o is 1, ready_o is 0 and rst_pin_o is 0; osc_en_o is 0 when xtal_sel_i is 1 and 1 when xtal_sel_i is 0.
- R2: Assertion of rst_ni acts asynchronously on every output. After rst_ni rises, core_rst_o falls on the SYNC_STAGES-th rising clock edge.
- R3: With xtal_sel_i at 0, cpu_clk_en_o first reads 1 after rising edge SYNC_STAGES+1+CFG_CYCLES, counted from the release of rst_ni.
- R4: With xtal_sel_i at 1, the run phase starts 2^(STAB_MIN_EXP+code) cycles later than in R3. Here code is the value of stab_code_i, from 0 to 7.
- R5: A stab_code_i value above 7, possible when CODE_W exceeds 3, selects the longest wait, 2^(STAB_MIN_EXP+7) cycles.
- R6: ready_o is 1 for exactly the first cycle in which cpu_clk_en_o is 1. port_hiz_o falls in that same cycle. cpu_clk_en_o then stays 1 until reset.
- R7: If rst_ni falls during any wait, the sequence returns to reset hold. After the next release, the full wait of R3/R4 is counted again from zero.
- R8: rst_pin_o takes pin_wdata_i one edge after a cycle with pin_wr_i at 1, but only while cpu_clk_en_o is 1. Writes in any other phase are ignored, and any reset forces the pin to 0.
- R9: xtal_sel_i and stab_code_i are sampled when the configuration wait ends. Changing them during the stabilization wait does not change its length.
- R10: With xtal_sel_i at 1, osc_en_o is 1 from the first configuration-wait cycle onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | External reset pin, active low, asynchronous assertion |
| xtal_sel_i | input | 1 | 1: crystal/ceramic source, 0: internal oscillator or external clock |
| stab_code_i | input | CODE_W | Stabilization length code |
| pin_wr_i | input | 1 | Software write strobe for the dedicated pin latch |
| pin_wdata_i | input | 1 | Value written to the dedicated pin latch |
| core_rst_o | output | 1 | Internal reset to the core, active high |
| cpu_clk_en_o | output | 1 | Core clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| port_hiz_o | output | 1 | Holds general ports high-impedance |
| rst_pin_o | output | 1 | Drive level of the dedicated port pin |
| ready_o | output | 1 | One-cycle pulse on entry to normal operation |

## Verification
The bench counts clock edges from reset release to the first run cycle, for both clock sources and for several stabilization codes. An off-by-one counter, a missing synchronizer stage or a wrong exponent would show up as a run start shifted by one or more cycles. Separate runs check the following:
- An out-of-range code must give the longest wait and must not wrap to a short one.
- A reset during the wait must restart the count from zero and must not resume it.
- A code change during stabilization must not shorten the wait, which would happen if the code were read continuously.
- Writes to the dedicated pin during the waits must be dropped, and the pin must be driven low again the moment reset returns.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_CFG  = 2'd1,
    ST_STAB = 2'd2,
    ST_RUN  = 2'd3
  } rrs_state_e;

  localparam int unsigned NUM_STAB_CODES = 8;
endpackage

// File: rtl/rrs_sync.sv
module rrs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rel_o
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rel_o = sync_q[STAGES-1];
endmodule

// File: rtl/rrs_stab_limit.sv
module rrs_stab_limit #(
  parameter int unsigned CODE_W       = 3,
  parameter int unsigned STAB_MIN_EXP = 10,
  parameter int unsigned CNT_W        = 18
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  limit_o
);
  import rrs_pkg::*;

  localparam int unsigned MAX_EXP = STAB_MIN_EXP + NUM_STAB_CODES - 1;

  logic [CNT_W-1:0] lim_tab [NUM_STAB_CODES];

  for (genvar g = 0; g < NUM_STAB_CODES; g++) begin : g_lim
    assign lim_tab[g] = (CNT_W'(1) << (STAB_MIN_EXP + g)) - CNT_W'(1);
  end

  // out-of-range codes fall back to the longest wait
  always_comb begin
    limit_o = (CNT_W'(1) << MAX_EXP) - CNT_W'(1);
    for (int i = 0; i < NUM_STAB_CODES; i++) begin
      if (int'(code_i) == i) limit_o = lim_tab[i];
    end
  end
endmodule

// File: rtl/rrs_seq_fsm.sv
module rrs_seq_fsm #(
  parameter int unsigned CFG_CYCLES = 2770,
  parameter int unsigned CNT_W      = 18
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rel_i,
  input  logic                xtal_sel_i,
  input  logic [CNT_W-1:0]    stab_lim_i,
  output rrs_pkg::rrs_state_e state_o,
  output logic                ready_o
);
  import rrs_pkg::*;

  localparam logic [CNT_W-1:0] CFG_LAST = CNT_W'(CFG_CYCLES - 1);

  rrs_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic             ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
      lim_q   <= '0;
      ready_q <= 1'b0;
    end else if (!rel_i) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      ready_q <= 1'b0;
      unique case (state_q)
        ST_HOLD: begin
          state_q <= ST_CFG;
          cnt_q   <= '0;
        end
        ST_CFG: begin
          if (cnt_q == CFG_LAST) begin
            cnt_q <= '0;
            lim_q <= stab_lim_i;
            if (xtal_sel_i) begin
              state_q <= ST_STAB;
            end else begin
              state_q <= ST_RUN;
              ready_q <= 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_STAB: begin
          if (cnt_q == lim_q) begin
            cnt_q   <= '0;
            state_q <= ST_RUN;
            ready_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_RUN: state_q <= ST_RUN;
        default: state_q <= ST_HOLD;
      endcase
    end
  end

  assign state_o = state_q;
  assign ready_o = ready_q;
endmodule

// File: rtl/rrs_pin_latch.sv
module rrs_pin_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic wr_i,
  input  logic wdata_i,
  output logic pin_o
);
  logic pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            pin_q <= 1'b0;
    else if (!run_i)        pin_q <= 1'b0;
    else if (wr_i)          pin_q <= wdata_i;
  end

  assign pin_o = pin_q;
endmodule

// File: rtl/mcu_rst_release.sv
module mcu_rst_release #(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned CFG_CYCLES   = 2770,
  parameter int unsigned STAB_MIN_EXP = 10,
  parameter int unsigned CODE_W       = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xtal_sel_i,
  input  logic [CODE_W-1:0] stab_code_i,
  input  logic              pin_wr_i,
  input  logic              pin_wdata_i,
  output logic              core_rst_o,
  output logic              cpu_clk_en_o,
  output logic              osc_en_o,
  output logic              port_hiz_o,
  output logic              rst_pin_o,
  output logic              ready_o
);
  import rrs_pkg::*;

  localparam int unsigned MAX_EXP = STAB_MIN_EXP + NUM_STAB_CODES - 1;
  localparam int unsigned CFG_W   = $clog2(CFG_CYCLES + 1);
  localparam int unsigned CNT_W   = ((CFG_W > MAX_EXP) ? CFG_W : MAX_EXP) + 1;

  logic             rel;
  logic [CNT_W-1:0] stab_lim;
  rrs_state_e       state;
  logic             run;

  rrs_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rel_o  (rel)
  );

  rrs_stab_limit #(
    .CODE_W       (CODE_W),
    .STAB_MIN_EXP (STAB_MIN_EXP),
    .CNT_W        (CNT_W)
  ) i_stab_limit (
    .code_i  (stab_code_i),
    .limit_o (stab_lim)
  );

  rrs_seq_fsm #(
    .CFG_CYCLES (CFG_CYCLES),
    .CNT_W      (CNT_W)
  ) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rel_i      (rel),
    .xtal_sel_i (xtal_sel_i),
    .stab_lim_i (stab_lim),
    .state_o    (state),
    .ready_o    (ready_o)
  );

  rrs_pin_latch i_pin (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .wr_i    (pin_wr_i),
    .wdata_i (pin_wdata_i),
    .pin_o   (rst_pin_o)
  );

  assign run          = (state == ST_RUN);
  assign core_rst_o   = !rel;
  assign cpu_clk_en_o = run;
  assign port_hiz_o   = !run;
  // crystal is stopped only in reset hold; other sources keep running
  assign osc_en_o     = !xtal_sel_i || (state != ST_HOLD);
endmodule

// File: rtl/rrs_checker.sv
module rrs_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic xtal_sel_i,
  input logic core_rst_o,
  input logic cpu_clk_en_o,
  input logic osc_en_o,
  input logic port_hiz_o,
  input logic rst_pin_o,
  input logic ready_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_outputs_R1: assert (core_rst_o && !cpu_clk_en_o && port_hiz_o
                                       && !rst_pin_o && !ready_o)
        else $error("reset outputs wrong");
    end
  end

  assert_no_run_in_reset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o |-> (!cpu_clk_en_o && port_hiz_o));

  assert_ready_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  assert_ready_on_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_clk_en_o) |-> (ready_o && !port_hiz_o));

  assert_run_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_clk_en_o |=> cpu_clk_en_o);

  assert_pin_only_in_run_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rst_pin_o) |-> $past(cpu_clk_en_o));

  assert_osc_on_in_run_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_clk_en_o |-> osc_en_o);
endmodule

bind mcu_rst_release rrs_checker i_rrs_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .xtal_sel_i   (xtal_sel_i),
  .core_rst_o   (core_rst_o),
  .cpu_clk_en_o (cpu_clk_en_o),
  .osc_en_o     (osc_en_o),
  .port_hiz_o   (port_hiz_o),
  .rst_pin_o    (rst_pin_o),
  .ready_o      (ready_o)
);

// File: tb/test_mcu_rst_release.sv
module test_mcu_rst_release;
  localparam int unsigned SYNC   = 2;
  localparam int unsigned CFG    = 40;
  localparam int unsigned MINE   = 4;
  localparam int unsigned CODE_W = 4;
  localparam int          BASE   = SYNC + 1 + CFG;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              xtal_sel_i = 1'b0;
  logic [CODE_W-1:0] stab_code_i = '0;
  logic              pin_wr_i = 1'b0;
  logic              pin_wdata_i = 1'b0;
  logic core_rst_o, cpu_clk_en_o, osc_en_o, port_hiz_o, rst_pin_o, ready_o;

  int n_checks = 0;
  int n_err    = 0;

  always #2 clk_i = ~clk_i;

  mcu_rst_release #(
    .SYNC_STAGES (SYNC),
    .CFG_CYCLES  (CFG),
    .STAB_MIN_EXP(MINE),
    .CODE_W      (CODE_W)
  ) i_mcu_rst_release (
    .clk_i, .rst_ni, .xtal_sel_i, .stab_code_i, .pin_wr_i, .pin_wdata_i,
    .core_rst_o, .cpu_clk_en_o, .osc_en_o, .port_hiz_o, .rst_pin_o, .ready_o
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    @(negedge clk_i);
  endtask

  // releases reset at a negedge and counts edges up to the first run cycle
  task automatic release_and_measure(output int n_run, output int n_rel,
                                     output bit hiz_ok, output bit osc_ok,
                                     input int chg_at, input logic [CODE_W-1:0] chg_code);
    n_run = -1; n_rel = -1; hiz_ok = 1'b1; osc_ok = 1'b1;
    rst_ni = 1'b1;
    for (int n = 1; n < 5000; n++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      if (n_rel < 0 && !core_rst_o) n_rel = n;
      if (n == chg_at) stab_code_i = chg_code;
      if (cpu_clk_en_o) begin n_run = n; break; end
      if (!port_hiz_o) hiz_ok = 1'b0;
      if (n > SYNC + 1 && !osc_en_o) osc_ok = 1'b0;
    end
  endtask

  task automatic t_reset_state();
    xtal_sel_i = 1'b1;
    do_reset();
    check(core_rst_o == 1'b1, "R1 core_rst", core_rst_o, 1);
    check(cpu_clk_en_o == 1'b0 && port_hiz_o == 1'b1, "R1 clk/hiz",
          {cpu_clk_en_o, port_hiz_o}, 1);
    check(rst_pin_o == 1'b0 && ready_o == 1'b0, "R1 pin/ready", {rst_pin_o, ready_o}, 0);
    check(osc_en_o == 1'b0, "R1 osc xtal", osc_en_o, 0);
    xtal_sel_i = 1'b0;
    #1;
    check(osc_en_o == 1'b1, "R1 osc internal", osc_en_o, 1);
  endtask

  task automatic t_internal_src();
    int nr, nl; bit h, o;
    xtal_sel_i = 1'b0;
    do_reset();
    release_and_measure(nr, nl, h, o, -1, '0);
    check(nl == SYNC, "R2 core_rst release edge", nl, SYNC);
    check(nr == BASE, "R3 run start", nr, BASE);
    check(ready_o == 1'b1 && port_hiz_o == 1'b0, "R6 ready/hiz at run", {ready_o, port_hiz_o}, 2);
    check(h, "R6 hiz held during waits", h, 1);
    @(negedge clk_i);
    check(ready_o == 1'b0 && cpu_clk_en_o == 1'b1, "R6 ready pulse one cycle",
          {ready_o, cpu_clk_en_o}, 1);
  endtask

  task automatic t_xtal(input logic [CODE_W-1:0] code, input int exp_w, input string req);
    int nr, nl; bit h, o;
    xtal_sel_i = 1'b1;
    stab_code_i = code;
    do_reset();
    release_and_measure(nr, nl, h, o, -1, '0);
    check(nr == BASE + exp_w, req, nr, BASE + exp_w);
    check(o, "R10 osc on after hold", o, 1);
  endtask

  task automatic t_abort();
    int nr, nl; bit h, o;
    xtal_sel_i = 1'b1;
    stab_code_i = '0;
    do_reset();
    rst_ni = 1'b1;
    repeat (BASE + 5) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check(core_rst_o && port_hiz_o && !cpu_clk_en_o, "R7 async return to hold",
          {core_rst_o, port_hiz_o, cpu_clk_en_o}, 6);
    @(negedge clk_i);
    release_and_measure(nr, nl, h, o, -1, '0);
    check(nr == BASE + (1 << MINE), "R7 full restart", nr, BASE + (1 << MINE));
  endtask

  task automatic t_code_change();
    int nr, nl; bit h, o;
    xtal_sel_i = 1'b1;
    stab_code_i = 4'd0;
    do_reset();
    release_and_measure(nr, nl, h, o, BASE + 2, 4'd7);
    check(nr == BASE + (1 << MINE), "R9 code sampled once", nr, BASE + (1 << MINE));
    stab_code_i = '0;
  endtask

  task automatic t_pin();
    int nr, nl; bit h, o;
    xtal_sel_i = 1'b0;
    do_reset();
    pin_wr_i = 1'b1;
    pin_wdata_i = 1'b1;
    release_and_measure(nr, nl, h, o, -1, '0);
    check(rst_pin_o == 1'b0, "R8 write ignored during waits", rst_pin_o, 0);
    @(negedge clk_i);
    check(rst_pin_o == 1'b1, "R8 write in run", rst_pin_o, 1);
    pin_wdata_i = 1'b0;
    @(negedge clk_i);
    check(rst_pin_o == 1'b0, "R8 write low in run", rst_pin_o, 0);
    pin_wdata_i = 1'b1;
    @(negedge clk_i);
    pin_wr_i = 1'b0;
    pin_wdata_i = 1'b0;
    @(negedge clk_i);
    check(rst_pin_o == 1'b1, "R8 latch holds", rst_pin_o, 1);
    rst_ni = 1'b0;
    #1;
    check(rst_pin_o == 1'b0, "R8 reset forces low", rst_pin_o, 0);
  endtask

  initial begin
    t_reset_state();
    t_internal_src();
    t_xtal(4'd0, 1 << MINE, "R4 code 0");
    t_xtal(4'd3, 1 << (MINE + 3), "R4 code 3");
    t_xtal(4'd7, 1 << (MINE + 7), "R4 code 7");
    t_xtal(4'd9, 1 << (MINE + 7), "R5 code 9 longest");
    t_xtal(4'd15, 1 << (MINE + 7), "R5 code 15 longest");
    t_abort();
    t_code_change();
    t_pin();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    #400000;
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule